// File: doc/BRIEF.md
# I2C Port-Expander Slave with Change Interrupt

This block is the serial front end of an 8-bit I/O expander. It listens on a two-wire I2C bus as a slave. It answers one 7-bit address, formed from a fixed 5-bit prefix followed by two strap pins. It holds four byte-wide registers: a read-only view of the port pins, an output latch, a per-bit polarity inverter and a per-bit direction mask. A write transaction first sets a 2-bit register pointer and then loads data into the selected register. A read transaction, either after a repeated START or on its own, streams the selected register back to the master.

The pointer persists from one transaction to the next, so a bare read keeps returning the same register. That makes polling the pins a single address byte followed by data. An active-low interrupt line reports that an input-direction pin has moved away from the value captured by the last read of the pin register. The next capture of that register clears the line at the acknowledge clock, without waiting for a STOP.

Top module: `xp_i2c_expander`

## Requirements
- R1: The slave acknowledges, by pulling SDA low through the 9th clock, only an address byte whose upper 7 bits equal {ADDR_PREFIX (default 5'b11100), addr_pins[1], addr_pins[0]}. A non-matching address is not acknowledged, and every later byte is ignored and not acknowledged until the next START.
- R2: In a write transaction (R/W bit = 0), the first byte after the address is a command byte, which the slave acknowledges. Its bits [1:0] become the pointer: 0 = pin (input) register, 1 = output latch, 2 = polarity mask, 3 = direction mask.
- R3: Each further byte of a write transaction is acknowledged and stored into the register the pointer selects, with every byte going to that same register. A byte written while the pointer is 0 is acknowledged but changes no register.
- R4: After a matching address with R/W = 1 is acknowledged, the slave sends the selected register MSB first. Pointer 0 returns the pin value XOR the polarity mask; pointers 1 to 3 return the stored register.
- R5: While the master acknowledges, the slave keeps sending bytes. The pin register is re-captured at the rising SCL edge of each acknowledge clock. After a master NACK the slave releases SDA and sends nothing more until the next START.
- R6: The pointer changes only through a command byte, so a read with no command byte returns the previously selected register. This holds both after a repeated START and in a new transaction.
- R7: After reset: output latch 8'hFF, polarity 8'h00, direction 8'hFF (all inputs), pointer 0, int_n high, SDA released, capture snapshot 8'h00.
- R8: int_n is driven low when any pin whose direction bit is 1 differs from the snapshot taken at the last pin-register capture. Pins with direction bit 0 never cause it.
- R9: int_n returns high when a pin-register byte is captured for a read, during that acknowledge phase and before any STOP. It also returns high when the pins come back to the snapshot value.
- R10: A STOP at any point releases SDA and returns the slave to idle. Registers written by completed bytes keep their values, and a partly received byte is discarded.
- R11: The slave changes sda_pull only after a falling SCL edge, a START or a STOP, so SDA is stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the pin |
| sda_i | input | 1 | I2C data line as seen on the pin |
| addr_pins | input | 2 | Strap pins forming the two low address bits |
| port_in | input | 8 | Current levels of the expander pins |
| sda_pull | output | 1 | 1 enables the open-drain pull-down on SDA |
| int_n | output | 1 | Active-low change interrupt |
| out_reg | output | 8 | Output latch value |
| pol_reg | output | 8 | Polarity inversion mask |
| cfg_reg | output | 8 | Direction mask, 1 = input |

## Verification
Several rules are checked on every cycle. The assertions confirm that the acknowledge follows only a matching address, that a STOP drops the pull-down, and that SDA moves only after a falling SCL or a bus condition. They also confirm that the pointer moves only on a command byte, that a pin-register capture with steady pins clears the interrupt, that a write to the pin register leaves the other registers untouched, and that an all-output direction mask keeps the interrupt high. The value of each transmitted byte, the polarity applied to captured pins, the re-capture between the bytes of one burst, and the masking of output-direction pins in the interrupt can only be shown by the bench's bus scenarios. The same holds for a STOP cutting off a half-written byte and for a mismatched address keeping the slave deaf to its later bytes.

// File: rtl/xp_pkg.sv
package xp_pkg;

  localparam int BYTE_W   = 8;
  localparam int PREFIX_W = 5;
  localparam int PTR_W    = 2;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_ADDR,
    BS_CMD,
    BS_WDATA,
    BS_RDATA
  } bus_state_t;

  localparam logic [PTR_W-1:0] SEL_PINS = 2'd0;
  localparam logic [PTR_W-1:0] SEL_OUT  = 2'd1;
  localparam logic [PTR_W-1:0] SEL_POL  = 2'd2;
  localparam logic [PTR_W-1:0] SEL_DIR  = 2'd3;

  // Upper seven bits of the received address byte against prefix and straps.
  function automatic logic addr_match(input logic [BYTE_W-1:0]   rx,
                                      input logic [PREFIX_W-1:0] prefix,
                                      input logic [1:0]          pins);
    return rx[BYTE_W-1:1] == {prefix, pins};
  endfunction

  // Byte presented to the master for a given pointer.
  function automatic logic [BYTE_W-1:0] read_value(input logic [PTR_W-1:0]  sel,
                                                   input logic [BYTE_W-1:0] pins,
                                                   input logic [BYTE_W-1:0] outv,
                                                   input logic [BYTE_W-1:0] pol,
                                                   input logic [BYTE_W-1:0] dir);
    logic [BYTE_W-1:0] v;
    case (sel)
      SEL_PINS: v = pins ^ pol;
      SEL_OUT:  v = outv;
      SEL_POL:  v = pol;
      default:  v = dir;
    endcase
    return v;
  endfunction

  // An input-direction pin has moved away from the last captured value.
  function automatic logic change_pending(input logic [BYTE_W-1:0] pins,
                                          input logic [BYTE_W-1:0] snap,
                                          input logic [BYTE_W-1:0] dir);
    return |((pins ^ snap) & dir);
  endfunction

endpackage

// File: rtl/xp_sync.sv
module xp_sync #(
  parameter int              W      = 1,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    RST_V  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_V;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_V}};
        else        chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/xp_bus_lines.sv
module xp_bus_lines #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [1:0] lines_s;
  logic       scl_s;
  logic       scl_d;
  logic       sda_d;

  xp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_V(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     (lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_d;
  assign scl_fall  = ~scl_s &  scl_d;
  assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
  assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;

endmodule

// File: rtl/xp_byte_engine.sv
module xp_byte_engine
  import xp_pkg::*;
#(
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b11100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        addr_pins,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_pull,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              addr_done,
  output logic              addr_hit,
  output logic              cmd_stb,
  output logic              wr_stb,
  output logic              load_stb
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  bus_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic              in_ack;
  logic              rw;
  logic              pull;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic              byte_end;
  logic              rx_state;

  assign rx_state  = (state == BS_ADDR) || (state == BS_CMD) || (state == BS_WDATA);
  assign byte_end  = scl_fall && !in_ack && (cnt == FULL);

  assign addr_done = byte_end && (state == BS_ADDR);
  assign addr_hit  = addr_done && addr_match(sh, ADDR_PREFIX, addr_pins);
  assign cmd_stb   = byte_end && (state == BS_CMD);
  assign wr_stb    = byte_end && (state == BS_WDATA);
  assign load_stb  = in_ack && scl_rise &&
                     (((state == BS_ADDR) && rw) || ((state == BS_RDATA) && !sda_s));
  assign rx_byte   = sh;
  assign sda_pull  = pull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= BS_IDLE;
      cnt    <= '0;
      in_ack <= 1'b0;
      rw     <= 1'b0;
      pull   <= 1'b0;
      sh     <= '0;
      tx     <= '1;
    end else if (start_det) begin
      state  <= BS_ADDR;
      cnt    <= '0;
      in_ack <= 1'b0;
      pull   <= 1'b0;
    end else if (stop_det) begin
      state  <= BS_IDLE;
      cnt    <= '0;
      in_ack <= 1'b0;
      pull   <= 1'b0;
    end else if (rx_state) begin
      if (!in_ack) begin
        if (scl_rise && (cnt < FULL)) begin
          sh  <= {sh[BYTE_W-2:0], sda_s};
          cnt <= cnt + 1'b1;
        end else if (byte_end) begin
          if ((state == BS_ADDR) && !addr_hit) begin
            state <= BS_IDLE;
          end else begin
            pull   <= 1'b1;
            in_ack <= 1'b1;
            if (state == BS_ADDR) rw <= sh[0];
          end
        end
      end else begin
        if (load_stb) tx <= rd_byte;
        if (scl_fall) begin
          in_ack <= 1'b0;
          cnt    <= '0;
          case (state)
            BS_ADDR: begin
              if (rw) begin
                state <= BS_RDATA;
                pull  <= ~tx[BYTE_W-1];
              end else begin
                state <= BS_CMD;
                pull  <= 1'b0;
              end
            end
            BS_CMD:  begin
              state <= BS_WDATA;
              pull  <= 1'b0;
            end
            default: pull <= 1'b0;
          endcase
        end
      end
    end else if (state == BS_RDATA) begin
      if (!in_ack) begin
        if (scl_rise && (cnt < FULL)) begin
          cnt <= cnt + 1'b1;
        end else if (scl_fall && (cnt < FULL) && (cnt != '0)) begin
          tx   <= {tx[BYTE_W-2:0], 1'b1};
          pull <= ~tx[BYTE_W-2];
        end else if (scl_fall && (cnt == FULL)) begin
          pull   <= 1'b0;
          in_ack <= 1'b1;
        end
      end else begin
        if (scl_rise) begin
          if (load_stb) begin
            tx <= rd_byte;
          end else begin
            state  <= BS_IDLE;
            in_ack <= 1'b0;
          end
        end else if (scl_fall) begin
          in_ack <= 1'b0;
          cnt    <= '0;
          pull   <= ~tx[BYTE_W-1];
        end
      end
    end
  end

endmodule

// File: rtl/xp_regs.sv
module xp_regs
  import xp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] port_in,
  input  logic              cmd_stb,
  input  logic              wr_stb,
  input  logic              load_stb,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] out_reg,
  output logic [BYTE_W-1:0] pol_reg,
  output logic [BYTE_W-1:0] cfg_reg,
  output logic [PTR_W-1:0]  ptr,
  output logic [BYTE_W-1:0] port_seen,
  output logic              int_n
);

  logic [BYTE_W-1:0] snap;

  xp_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_V('0)) u_port_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (port_in),
    .q     (port_seen)
  );

  assign rd_byte = read_value(ptr, port_seen, out_reg, pol_reg, cfg_reg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= SEL_PINS;
      out_reg <= '1;
      pol_reg <= '0;
      cfg_reg <= '1;
      snap    <= '0;
      int_n   <= 1'b1;
    end else begin
      if (cmd_stb) ptr <= rx_byte[PTR_W-1:0];
      if (wr_stb) begin
        case (ptr)
          SEL_OUT: out_reg <= rx_byte;
          SEL_POL: pol_reg <= rx_byte;
          SEL_DIR: cfg_reg <= rx_byte;
          default: ;
        endcase
      end
      if (load_stb && (ptr == SEL_PINS)) snap <= port_seen;
      int_n <= ~change_pending(port_seen, snap, cfg_reg);
    end
  end

endmodule

// File: rtl/xp_i2c_expander.sv
module xp_i2c_expander
  import xp_pkg::*;
#(
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b11100,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_pins,
  input  logic [BYTE_W-1:0] port_in,
  output logic              sda_pull,
  output logic              int_n,
  output logic [BYTE_W-1:0] out_reg,
  output logic [BYTE_W-1:0] pol_reg,
  output logic [BYTE_W-1:0] cfg_reg
);

  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] rd_byte;
  logic [BYTE_W-1:0] port_seen;
  logic [PTR_W-1:0]  ptr;
  logic              addr_done;
  logic              addr_hit;
  logic              cmd_stb;
  logic              wr_stb;
  logic              load_stb;

  xp_bus_lines #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  xp_byte_engine #(.ADDR_PREFIX(ADDR_PREFIX)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_pins (addr_pins),
    .rd_byte   (rd_byte),
    .sda_pull  (sda_pull),
    .rx_byte   (rx_byte),
    .addr_done (addr_done),
    .addr_hit  (addr_hit),
    .cmd_stb   (cmd_stb),
    .wr_stb    (wr_stb),
    .load_stb  (load_stb)
  );

  xp_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_in   (port_in),
    .cmd_stb   (cmd_stb),
    .wr_stb    (wr_stb),
    .load_stb  (load_stb),
    .rx_byte   (rx_byte),
    .rd_byte   (rd_byte),
    .out_reg   (out_reg),
    .pol_reg   (pol_reg),
    .cfg_reg   (cfg_reg),
    .ptr       (ptr),
    .port_seen (port_seen),
    .int_n     (int_n)
  );

endmodule

// File: rtl/xp_checker.sv
module xp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull,
  input logic       int_n,
  input logic [7:0] out_reg,
  input logic [7:0] pol_reg,
  input logic [7:0] cfg_reg,
  input logic [1:0] ptr,
  input logic [7:0] port_seen,
  input logic       addr_done,
  input logic       addr_hit,
  input logic       cmd_stb,
  input logic       wr_stb,
  input logic       load_stb,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det
);

  // R1: a matching address is acknowledged, a foreign one is not
  p_ack_on_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> sda_pull);
  p_no_ack_on_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_hit) |=> !sda_pull);

  // R3: a write with pointer 0 leaves every register alone
  p_pins_readonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && ptr == 2'd0) |=> ($stable(out_reg) && $stable(pol_reg) && $stable(cfg_reg)));

  // R6: the pointer moves only on a command byte
  p_ptr_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_stb |=> $stable(ptr));

  // R8: with every pin an output no interrupt is raised
  p_outputs_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_reg == 8'h00) |=> int_n);

  // R9: a pin capture with steady pins clears the interrupt
  p_capture_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((load_stb && ptr == 2'd0) ##1 $stable(port_seen)) |=> int_n);

  // R10: a STOP releases the data line
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  // R11: the pull-down moves only after a falling SCL or a bus condition
  p_sda_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(scl_fall || start_det || stop_det));

endmodule

bind xp_i2c_expander xp_checker u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_pull  (sda_pull),
  .int_n     (int_n),
  .out_reg   (out_reg),
  .pol_reg   (pol_reg),
  .cfg_reg   (cfg_reg),
  .ptr       (ptr),
  .port_seen (port_seen),
  .addr_done (addr_done),
  .addr_hit  (addr_hit),
  .cmd_stb   (cmd_stb),
  .wr_stb    (wr_stb),
  .load_stb  (load_stb),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det)
);

// File: tb/tb_xp_i2c_expander.sv
`timescale 1ns/1ps
module tb_xp_i2c_expander;

  localparam int Q = 10;                 // system clocks per quarter SCL period
  localparam logic [4:0] PFX = 5'b11100;

  typedef struct {
    string      req;
    logic [7:0] val;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] straps = 2'b10;
  logic [7:0] pins = 8'h00;
  logic       sda_pull;
  logic       int_n;
  logic [7:0] out_reg;
  logic [7:0] pol_reg;
  logic [7:0] cfg_reg;
  logic       sda_line;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  item_t exp_q[$];
  item_t act_q[$];
  event  obs_ev;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  xp_i2c_expander dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .addr_pins (straps),
    .port_in   (pins),
    .sda_pull  (sda_pull),
    .int_n     (int_n),
    .out_reg   (out_reg),
    .pol_reg   (pol_reg),
    .cfg_reg   (cfg_reg)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected items as observed ones arrive.
  initial begin
    item_t a;
    item_t e;
    forever begin
      @(obs_ev);
      while (act_q.size() > 0) begin
        a = act_q.pop_front();
        if (exp_q.size() == 0) begin
          chk("scoreboard-empty", a.val, 8'hxx);
        end else begin
          e = exp_q.pop_front();
          chk(e.req, a.val, e.val);
        end
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    b = sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  // Driver: sends a byte and scores the slave's acknowledge (0 = ACK, 1 = NACK).
  task automatic send_byte(input logic [7:0] b, input logic exp_nack, input string req);
    logic early;
    logic late;
    item_t it;
    it.req = req; it.val = {7'd0, exp_nack};
    exp_q.push_back(it);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(2);
    early = sda_line; wq(2*Q - 4);
    late = sda_line; wq(2);
    scl_m = 1'b0; wq(Q);
    chk("R11", {7'd0, late}, {7'd0, early});
    it.val = {7'd0, late};
    act_q.push_back(it);
    -> obs_ev;
  endtask

  // Driver: reads a byte, scores it, then gives ACK (more=1) or NACK.
  task automatic recv_byte(input logic [7:0] exp, input logic more, input string req);
    logic [7:0] v;
    logic b;
    item_t it;
    it.req = req; it.val = exp;
    exp_q.push_back(it);
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~more);
    it.val = v;
    act_q.push_back(it);
    -> obs_ev;
  endtask

  function automatic logic [7:0] addr_byte(input logic [1:0] p, input logic rd);
    return {PFX, p, rd};
  endfunction

  task automatic write_reg(input logic [1:0] sel, input logic [7:0] d, input string req);
    bus_start();
    send_byte(addr_byte(straps, 1'b0), 1'b0, "R1");
    send_byte({6'd0, sel}, 1'b0, "R2");
    send_byte(d, 1'b0, req);
    bus_stop();
  endtask

  task automatic bare_read(input logic [7:0] exp, input string req);
    bus_start();
    send_byte(addr_byte(straps, 1'b1), 1'b0, "R1");
    recv_byte(exp, 1'b0, req);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wq(5);
    rst_n = 1'b1;
    wq(5);

    // R7 reset state
    chk("R7", out_reg, 8'hFF);
    chk("R7", pol_reg, 8'h00);
    chk("R7", cfg_reg, 8'hFF);
    chk("R7", {7'd0, int_n}, 8'h01);
    chk("R7", {7'd0, sda_pull}, 8'h00);

    // R2/R3: output latch, two bytes to the same register
    bus_start();
    send_byte(addr_byte(straps, 1'b0), 1'b0, "R1");
    send_byte(8'h01, 1'b0, "R2");
    send_byte(8'h5A, 1'b0, "R3");
    wq(5);
    chk("R3", out_reg, 8'h5A);
    send_byte(8'h3C, 1'b0, "R3");
    bus_stop();
    chk("R3", out_reg, 8'h3C);

    write_reg(2'd2, 8'h0F, "R3");
    chk("R3", pol_reg, 8'h0F);

    // R4/R6: command then repeated START read
    bus_start();
    send_byte(addr_byte(straps, 1'b0), 1'b0, "R1");
    send_byte(8'h01, 1'b0, "R2");
    bus_rstart();
    send_byte(addr_byte(straps, 1'b1), 1'b0, "R1");
    recv_byte(8'h3C, 1'b0, "R4");
    wq(5);
    chk("R5", {7'd0, sda_pull}, 8'h00);
    bus_stop();

    bare_read(8'h3C, "R6");

    // R3: writes with pointer 0 change nothing
    write_reg(2'd0, 8'hAA, "R3");
    chk("R3", out_reg, 8'h3C);
    chk("R3", pol_reg, 8'h0F);
    chk("R3", cfg_reg, 8'hFF);

    // R8/R9: interrupt raised by pins, cleared at capture without STOP
    pins = 8'hA5;
    wq(10);
    chk("R8", {7'd0, int_n}, 8'h00);
    bus_start();
    send_byte(addr_byte(straps, 1'b0), 1'b0, "R1");
    send_byte(8'h00, 1'b0, "R2");
    bus_rstart();
    send_byte(addr_byte(straps, 1'b1), 1'b0, "R1");
    chk("R9", {7'd0, int_n}, 8'h01);
    pins = 8'h5A;
    wq(10);
    chk("R8", {7'd0, int_n}, 8'h00);
    recv_byte(8'hAA, 1'b1, "R4");
    recv_byte(8'h55, 1'b0, "R5");
    chk("R9", {7'd0, int_n}, 8'h01);
    bus_stop();

    // R8 masking by direction, R9 return to snapshot
    write_reg(2'd3, 8'h0F, "R3");
    chk("R3", cfg_reg, 8'h0F);
    pins = 8'hFA;
    wq(10);
    chk("R8", {7'd0, int_n}, 8'h01);
    pins = 8'hFB;
    wq(10);
    chk("R8", {7'd0, int_n}, 8'h00);
    pins = 8'h5A;
    wq(10);
    chk("R9", {7'd0, int_n}, 8'h01);
    bare_read(8'h0F, "R4");

    // R1: foreign address, later bytes ignored
    bus_start();
    send_byte(addr_byte(2'b01, 1'b0), 1'b1, "R1");
    send_byte(8'h03, 1'b1, "R1");
    send_byte(8'h00, 1'b1, "R1");
    bus_stop();
    chk("R1", cfg_reg, 8'h0F);

    // R10: STOP in the middle of a data byte
    bus_start();
    send_byte(addr_byte(straps, 1'b0), 1'b0, "R1");
    send_byte(8'h01, 1'b0, "R2");
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    chk("R10", out_reg, 8'h3C);
    chk("R10", {7'd0, sda_pull}, 8'h00);
    bare_read(8'h3C, "R10");

    // R5: three-byte burst
    bus_start();
    send_byte(addr_byte(straps, 1'b1), 1'b0, "R1");
    recv_byte(8'h3C, 1'b1, "R5");
    recv_byte(8'h3C, 1'b1, "R5");
    recv_byte(8'h3C, 1'b0, "R5");
    wq(5);
    chk("R5", {7'd0, sda_pull}, 8'h00);
    bus_stop();

    wq(20);
    if (exp_q.size() != 0) chk("scoreboard-left", 8'(exp_q.size()), 8'h00);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule